// File: doc/BRIEF.md
# Inter-VM Doorbell Register Block

This block is the register window of a shared-memory device that lets virtual machines signal one another. Software reaches it through a 256-byte window with 32-bit-only accesses. The window holds four registers: an interrupt mask, an interrupt status that clears when it is read, a read-only register that reports this device's own peer number, and a write-only doorbell. A doorbell write names a destination peer and a vector number. A small table of per-peer registered vector counts, loaded through a separate configuration port, is used to check that write. If the write is valid, the block emits a one-cycle notify pulse that carries the peer and the vector. If it is not valid, the write is dropped and nothing happens.

When message-signalled interrupts are disabled, an event arriving for this device loads the status register with 1. A level interrupt output is high while any bit is set in both the status and the mask registers. All register updates, read data and notify outputs are registered. Each appears on the cycle after the request that caused it.

Top module: `doorbell_regs`

## Requirements
- R1: After reset, the mask and status registers are zero, irq_o and notify_valid_o are low, rdata_o is zero, and every peer's vector count is zero.
- R2: A write to byte offset 0 stores all 32 bits of wdata_i in the mask register. A read of offset 0 returns the mask register on rdata_o in the next cycle.
- R3: A read of offset 4 returns the current status value in the next cycle and clears the status register in the same access. A second read returns zero.
- R4: Writes decode only addr_i[7:2], so offsets 1 to 3 write the mask register. Reads decode the full byte address. A read of any offset other than 0, 4 or 8 returns zero, and this includes the doorbell at offset 12 and the unaligned offsets. rdata_o is zero in any cycle that does not follow a read.
- R5: A read of offset 8 returns own_id_i zero-extended to 32 bits. Writes to offset 8 change no register.
- R6: A valid write to offset 12 puts dest = wdata_i[31:16] and vector = wdata_i[7:0] on the port. Bits 15:8 are ignored. In the next cycle the block drives notify_valid_o high for exactly one cycle, with notify_peer_o = dest and notify_vector_o = vector.
- R7: A doorbell write with dest >= num_peers_i, or with dest >= MAX_PEERS, produces no notify pulse and has no other effect.
- R8: A doorbell write whose vector is not below the registered vector count of the destination peer produces no notify pulse.
- R9: With msi_en_i low, event_i loads the status register with exactly 1, overwriting its previous value. In the same cycle, event_i takes priority over a status write and over a status read-clear. The read still returns the old value.
- R10: With msi_en_i high, event_i leaves the status register unchanged.
- R11: irq_o is high exactly when the bitwise AND of the status and mask registers is non-zero.
- R12: When cfg_we_i is high, cfg_count_i is stored as the registered vector count of peer cfg_peer_i. The new count applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| own_id_i | input | 16 | This device's peer number |
| num_peers_i | input | 4 | Current number of peers |
| cfg_we_i | input | 1 | Vector-count table write strobe |
| cfg_peer_i | input | 3 | Table entry to write |
| cfg_count_i | input | 5 | Registered vector count for that peer |
| msi_en_i | input | 1 | Message-signalled interrupts enabled |
| event_i | input | 1 | Incoming local event |
| irq_o | output | 1 | Level interrupt |
| notify_valid_o | output | 1 | One-cycle doorbell notify strobe |
| notify_peer_o | output | 3 | Notified peer |
| notify_vector_o | output | 8 | Notified vector |

## Verification
The assertions assume the following about the inputs. A request is either a read or a write. The configuration port writes one peer entry per cycle. num_peers_i may change between cycles, and the assertions compare against the value it had when the doorbell was accepted. The stimulus holds every input steady across a clock edge and drives it half a period away from that edge. It mixes random offsets, including unaligned offsets and offsets outside the register set, with doorbell destinations and vectors on both sides of each limit, and with events that land on the same cycle as status reads and writes under both settings of msi_en_i.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_POS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_BELL = 8'h0C;

  typedef enum logic [1:0] {
    W_MASK = 2'd0,
    W_STAT = 2'd1,
    W_POS  = 2'd2,
    W_BELL = 2'd3
  } word_sel_e;
endpackage

// File: rtl/db_peer_table.sv
module db_peer_table #(
  parameter int MAX_PEERS = 8,
  parameter int MAX_VEC   = 16,
  localparam int PIDX_W   = $clog2(MAX_PEERS),
  localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [PIDX_W-1:0] cfg_peer_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [PIDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0]  rd_count_o
);
  logic [CNT_W-1:0] cnt_q [MAX_PEERS];

  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    cnt_q[p] <= '0;
      else if (cfg_we_i && cfg_peer_i == PIDX_W'(p))  cnt_q[p] <= cfg_count_i;
    end
  end

  assign rd_count_o = cnt_q[rd_idx_i];

  // R12
  cfg_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cnt_q[$past(cfg_peer_i)] == $past(cfg_count_i));
endmodule

// File: rtl/db_bell.sv
module db_bell #(
  parameter int MAX_PEERS = 8,
  parameter int MAX_VEC   = 16,
  localparam int PIDX_W   = $clog2(MAX_PEERS),
  localparam int CNT_W    = $clog2(MAX_VEC + 1),
  localparam int NP_W     = $clog2(MAX_PEERS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_bell_i,
  input  logic [doorbell_pkg::ID_W-1:0]  dest_i,
  input  logic [doorbell_pkg::VEC_W-1:0] vector_i,
  input  logic [NP_W-1:0]               num_peers_i,
  output logic [PIDX_W-1:0]             lut_idx_o,
  input  logic [CNT_W-1:0]              lut_count_i,
  output logic                          notify_valid_o,
  output logic [PIDX_W-1:0]             notify_peer_o,
  output logic [doorbell_pkg::VEC_W-1:0] notify_vector_o
);
  import doorbell_pkg::*;

  logic peer_ok, vec_ok, fire;

  assign lut_idx_o = dest_i[PIDX_W-1:0];
  assign peer_ok   = (dest_i < ID_W'(num_peers_i)) && (dest_i < ID_W'(MAX_PEERS));
  assign vec_ok    = vector_i < VEC_W'(lut_count_i);
  assign fire      = wr_bell_i && peer_ok && vec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_valid_o  <= 1'b0;
      notify_peer_o   <= '0;
      notify_vector_o <= '0;
    end else begin
      notify_valid_o <= fire;
      if (fire) begin
        notify_peer_o   <= lut_idx_o;
        notify_vector_o <= vector_i;
      end
    end
  end

  // R6
  notify_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> $past(wr_bell_i));
  // R7
  notify_peer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> NP_W'(notify_peer_o) < $past(num_peers_i));
  // R8
  notify_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> notify_vector_o < VEC_W'($past(lut_count_i)));
endmodule

// File: rtl/db_irq.sv
module db_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic              wr_stat_i,
  input  logic              rd_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              event_i,
  input  logic              msi_en_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic local_set;
  assign local_set = event_i && !msi_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      status_o <= '0;
    end else begin
      if (wr_mask_i) mask_o <= wdata_i;
      // local event outranks bus write and read-clear
      if (local_set)      status_o <= DATA_W'(1);
      else if (wr_stat_i) status_o <= wdata_i;
      else if (rd_stat_i) status_o <= '0;
    end
  end

  assign irq_o = |(status_o & mask_o);

  // R3
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !local_set) |=> status_o == '0);
  // R9
  event_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_set |=> status_o == DATA_W'(1));
  // R10
  msi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && msi_en_i && !wr_stat_i && !rd_stat_i) |=> $stable(status_o));
endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int MAX_PEERS = 8,
  parameter int MAX_VEC   = 16,
  localparam int PIDX_W   = $clog2(MAX_PEERS),
  localparam int CNT_W    = $clog2(MAX_VEC + 1),
  localparam int NP_W     = $clog2(MAX_PEERS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [doorbell_pkg::ADDR_W-1:0] addr_i,
  input  logic [doorbell_pkg::DATA_W-1:0] wdata_i,
  output logic [doorbell_pkg::DATA_W-1:0] rdata_o,
  input  logic [doorbell_pkg::ID_W-1:0]   own_id_i,
  input  logic [NP_W-1:0]                num_peers_i,
  input  logic                           cfg_we_i,
  input  logic [PIDX_W-1:0]              cfg_peer_i,
  input  logic [CNT_W-1:0]               cfg_count_i,
  input  logic                           msi_en_i,
  input  logic                           event_i,
  output logic                           irq_o,
  output logic                           notify_valid_o,
  output logic [PIDX_W-1:0]              notify_peer_o,
  output logic [doorbell_pkg::VEC_W-1:0]  notify_vector_o
);
  import doorbell_pkg::*;

  logic              wr, rd, wr_hit;
  logic [ADDR_W-3:0] waddr;
  word_sel_e         wsel;
  logic              wr_mask, wr_stat, wr_bell, rd_stat;
  logic [DATA_W-1:0] mask_q, status_q, rd_val;
  logic [PIDX_W-1:0] lut_idx;
  logic [CNT_W-1:0]  lut_count;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign waddr   = addr_i[ADDR_W-1:2];
  assign wr_hit  = wr && (waddr < (ADDR_W-2)'(4));
  assign wsel    = word_sel_e'(waddr[1:0]);
  assign wr_mask = wr_hit && wsel == W_MASK;
  assign wr_stat = wr_hit && wsel == W_STAT;
  assign wr_bell = wr_hit && wsel == W_BELL;
  assign rd_stat = rd && addr_i == OFF_STAT;

  always_comb begin
    unique case (addr_i)
      OFF_MASK: rd_val = mask_q;
      OFF_STAT: rd_val = status_q;
      OFF_POS:  rd_val = DATA_W'(own_id_i);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd ? rd_val : '0;
  end

  db_irq #(.DATA_W(DATA_W)) i_irq (
    .clk_i, .rst_ni,
    .wr_mask_i (wr_mask),
    .wr_stat_i (wr_stat),
    .rd_stat_i (rd_stat),
    .wdata_i   (wdata_i),
    .event_i   (event_i),
    .msi_en_i  (msi_en_i),
    .mask_o    (mask_q),
    .status_o  (status_q),
    .irq_o     (irq_o)
  );

  db_peer_table #(.MAX_PEERS(MAX_PEERS), .MAX_VEC(MAX_VEC)) i_table (
    .clk_i, .rst_ni,
    .cfg_we_i    (cfg_we_i),
    .cfg_peer_i  (cfg_peer_i),
    .cfg_count_i (cfg_count_i),
    .rd_idx_i    (lut_idx),
    .rd_count_o  (lut_count)
  );

  db_bell #(.MAX_PEERS(MAX_PEERS), .MAX_VEC(MAX_VEC)) i_bell (
    .clk_i, .rst_ni,
    .wr_bell_i       (wr_bell),
    .dest_i          (wdata_i[31:16]),
    .vector_i        (wdata_i[VEC_W-1:0]),
    .num_peers_i     (num_peers_i),
    .lut_idx_o       (lut_idx),
    .lut_count_i     (lut_count),
    .notify_valid_o  (notify_valid_o),
    .notify_peer_o   (notify_peer_o),
    .notify_vector_o (notify_vector_o)
  );

  // R4
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd) |-> rdata_o == '0);
  // R5
  pos_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd && addr_i == OFF_POS) |-> rdata_o == DATA_W'($past(own_id_i)));
endmodule

// File: tb/test_doorbell_regs.sv
`timescale 1ns/1ps
module test_doorbell_regs;
  localparam int NP = 8;

  logic        clk = 0, rst_ni = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] own_id = 16'h0005;
  logic [3:0]  num_peers = 4'd6;
  logic        cfg_we = 0;
  logic [2:0]  cfg_peer = 0;
  logic [4:0]  cfg_count = 0;
  logic        msi_en = 0, ev = 0;
  logic        irq, nv;
  logic [2:0]  npeer;
  logic [7:0]  nvec;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_mask = 0, m_stat = 0;
  logic [4:0]  m_cnt [NP];

  always #10 clk = ~clk;

  doorbell_regs i_doorbell_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .own_id_i(own_id), .num_peers_i(num_peers),
    .cfg_we_i(cfg_we), .cfg_peer_i(cfg_peer), .cfg_count_i(cfg_count),
    .msi_en_i(msi_en), .event_i(ev), .irq_o(irq), .notify_valid_o(nv),
    .notify_peer_o(npeer), .notify_vector_o(nvec)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return m_mask;
      8'h04: return m_stat;
      8'h08: return {16'h0, own_id};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit bell_ok(logic [31:0] d);
    logic [15:0] dst = d[31:16];
    if (dst >= 16'(num_peers) || dst >= 16'(NP)) return 0;
    return d[7:0] < 8'(m_cnt[dst[2:0]]);
  endfunction

  // one access; called at a negedge, returns at the following negedge
  task automatic acc(bit w, logic [7:0] a, logic [31:0] d, bit e, string tag);
    logic [31:0] er = 32'h0;
    bit          enf;
    logic [5:0]  wa = a[7:2];
    req = 1; we = w; addr = a; wdata = d; ev = e;
    if (!w) er = exp_read(a);
    enf = w && wa == 6'd3 && bell_ok(d);
    if (e && !msi_en)               m_stat = 32'h1;
    else if (w && wa == 6'd1)       m_stat = d;
    else if (!w && a == 8'h04)      m_stat = 0;
    if (w && wa == 6'd0) m_mask = d;
    @(negedge clk);
    req = 0; we = 0; ev = 0;
    chk(rdata == er, {tag, " rdata"}, rdata, er);
    chk(nv == enf, {tag, " notify_valid"}, 32'(nv), 32'(enf));
    if (enf) chk({npeer, nvec} == {d[18:16], d[7:0]}, {tag, " notify fields"},
                 {21'h0, npeer, nvec}, {21'h0, d[18:16], d[7:0]});
    chk(irq == |(m_stat & m_mask), {tag, "/R11 irq"}, 32'(irq), 32'(|(m_stat & m_mask)));
  endtask

  task automatic cfg(logic [2:0] p, logic [4:0] c);
    cfg_we = 1; cfg_peer = p; cfg_count = c;
    m_cnt[p] = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk(rdata == 0 && !irq && !nv, "R1 reset outputs", {rdata[29:0], irq, nv}, 0);
    acc(1, 8'h0C, {16'd0, 8'h00, 8'd0}, 0, "R1 R12 zero count drops bell");
    // R2
    acc(1, 8'h00, 32'hDEADBEEF, 0, "R2 mask write");
    acc(0, 8'h00, 0, 0, "R2 mask read");
    // R9 R3
    acc(0, 8'h10, 0, 1, "R9 event sets status");
    acc(0, 8'h04, 0, 0, "R3 status read");
    acc(0, 8'h04, 0, 0, "R3 status second read");
    acc(1, 8'h04, 32'h0000F0F0, 1, "R9 event beats write");
    acc(0, 8'h04, 0, 1, "R9 event beats read-clear");
    acc(0, 8'h04, 0, 0, "R9 status after collision");
    // R10
    msi_en = 1;
    acc(1, 8'h04, 32'h00000006, 0, "R10 status write");
    acc(0, 8'h00, 0, 1, "R10 msi event ignored");
    acc(0, 8'h04, 0, 0, "R10 status kept");
    msi_en = 0;
    // R4 R5
    acc(1, 8'h03, 32'h00000011, 0, "R4 unaligned mask write");
    acc(0, 8'h00, 0, 0, "R4 mask after unaligned");
    acc(0, 8'h01, 0, 0, "R4 unaligned read zero");
    acc(0, 8'h0C, 0, 0, "R4 doorbell reads zero");
    acc(1, 8'h08, 32'hFFFFFFFF, 0, "R5 position write ignored");
    acc(0, 8'h08, 0, 0, "R5 position read");
    // R12 R6 R7 R8
    cfg(3'd2, 5'd4);
    cfg(3'd7, 5'd16);
    acc(1, 8'h0C, {16'd2, 8'hA5, 8'd3}, 0, "R6 valid bell");
    acc(1, 8'h0C, {16'd2, 8'h00, 8'd4}, 0, "R8 vector at count");
    acc(1, 8'h0C, {16'd7, 8'h00, 8'd15}, 0, "R7 peer above num_peers");
    num_peers = 4'd8;
    acc(1, 8'h0C, {16'd7, 8'h00, 8'd15}, 0, "R6 top peer top vector");
    acc(1, 8'h0C, {16'd10, 8'h00, 8'd0}, 0, "R7 peer beyond table");
    acc(1, 8'h0C, {16'h0102, 8'h00, 8'd0}, 0, "R7 high dest bits");
    // random
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] a;
      logic [31:0] d;
      if (k == 0) cfg(3'($urandom_range(0, 7)), 5'($urandom_range(0, 16)));
      else begin
        case ($urandom_range(0, 8))
          0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3, 4: a = 8'h0C;
          5: a = 8'h01; 6: a = 8'h0E; 7: a = 8'h10; default: a = 8'hFC;
        endcase
        d = $urandom;
        if (a[7:2] == 6'd3) d = {16'($urandom_range(0, 9)), 8'($urandom), 8'($urandom_range(0, 17))};
        if ($urandom_range(0, 15) == 0) num_peers = 4'($urandom_range(0, 8));
        msi_en = ($urandom_range(0, 3) == 0);
        acc(($urandom_range(0, 1) == 1), a, d, ($urandom_range(0, 5) == 0), "R2-R12 random");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule